// File: doc/BRIEF.md
# Sequential Signed/Unsigned Multiplier

This block multiplies two W-bit operands (W = 32 by default) over several clock cycles with a single 2W-bit adder/subtractor, and returns the 2W-bit product as a high word and a low word on two separate output ports. A one-cycle start pulse loads both operands along with a mode bit. The mode bit selects an unsigned or a two's-complement signed product.

After start, the unit works through the multiplier one bit per clock, least significant bit first. On each step it adds to a running accumulator either the shifted multiplicand or zero. In signed mode the multiplicand is sign-extended to 2W bits. The step for the multiplier's top bit subtracts instead of adding, because that bit has a weight of -2^(W-1). When the last step is done, busy falls and done pulses for one cycle. The high and low words then hold their values until the next accepted start. Software reads them separately, the same way move-from-high and move-from-low instructions do.

Top module: `seq_mult`

## Requirements
- R1: After reset, busy and done are 0 and both hi and lo read 0.
- R2: With is_signed = 0, {hi, lo} equals the unsigned product of op_a and op_b, both taken as W-bit unsigned numbers.
- R3: With is_signed = 1, {hi, lo} equals the two's-complement product of op_a and op_b, both taken as W-bit signed numbers, written as a 2W-bit signed value.
- R4: With W = 4 in signed mode, -3 (4'b1101) times 5 (4'b0101) gives {hi, lo} = 8'b11110001.
- R5: The clock edge that samples start with busy low makes busy 1. Exactly W edges later, busy is 0 and done is 1. Done stays high for one cycle only.
- R6: A start that arrives while busy is 1 is ignored. The current product finishes on time and with the operands that were first loaded.
- R7: After done, hi and lo keep their values, and done stays 0, until the next accepted start.
- R8: Corner operands give correct results: zero, all ones unsigned, the most negative value times itself, and the most negative value times -1 in signed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a product when the unit is idle |
| is_signed | input | 1 | 1 = signed product, 0 = unsigned, sampled with start |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| busy | output | 1 | High while a product is being formed |
| done | output | 1 | One-cycle pulse when the product is ready |
| hi | output | W | Upper half of the product |
| lo | output | W | Lower half of the product |

## Verification
Most internal faults reach the result words. A wrong sign extension, a wrong choice between add and subtract on the top bit, or a stuck shift corrupts hi first. That shows up on the first signed product with a negative operand, or on the first unsigned product with a large operand. A faulty step counter moves the done pulse away from W cycles after start, which is seen on the very first operation. A faulty idle guard lets a start during busy reload the operands. The product returned then no longer matches the first pair of operands.

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int PW = 2 * W;
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  logic [PW-1:0] acc, mcand;
  logic [W-1:0]  mplier;
  logic [CW-1:0] step;
  logic          sgn;

  wire           last = (step == CW'(W - 1));
  wire [PW-1:0]  part = mplier[0] ? mcand : '0;
  wire [PW-1:0]  acc_nxt = (sgn && last) ? acc - part : acc + part;
  wire [PW-1:0]  a_ext = {{W{is_signed & op_a[W-1]}}, op_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      step   <= '0;
      sgn    <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (start && !busy) begin
      acc    <= '0;
      mcand  <= a_ext;
      mplier <= op_b;
      step   <= '0;
      sgn    <= is_signed;
      busy   <= 1'b1;
      done   <= 1'b0;
    end else if (busy) begin
      acc    <= acc_nxt;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
      step   <= step + 1'b1;
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign hi = acc[PW-1:W];
  assign lo = acc[W-1:0];
endmodule

// File: rtl/seq_mult_chk.sv
module seq_mult_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_start_accepted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({hi, lo}));
endmodule

bind seq_mult seq_mult_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .hi(hi), .lo(lo)
);

// File: tb/test_seq_mult.sv
module test_seq_mult;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, is_signed = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic busy, done;
  logic [W-1:0] hi, lo;

  logic s4_start = 1'b0, s4_sgn = 1'b0;
  logic [3:0] s4_a = '0, s4_b = '0;
  logic s4_busy, s4_done;
  logic [3:0] s4_hi, s4_lo;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  seq_mult #(.W(W)) i_seq_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  seq_mult #(.W(4)) i_seq_mult_w4 (
    .clk(clk), .rst_n(rst_n), .start(s4_start), .is_signed(s4_sgn),
    .op_a(s4_a), .op_b(s4_b), .busy(s4_busy), .done(s4_done),
    .hi(s4_hi), .lo(s4_lo)
  );

  function automatic logic [63:0] ref_prod(logic [31:0] a, logic [31:0] b, logic s);
    longint sa, sb;
    longint unsigned ua, ub;
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    ua = {32'd0, a};
    ub = {32'd0, b};
    return ua * ub;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(string req, logic [31:0] a, logic [31:0] b, logic s, bit poke);
    int n;
    logic [63:0] exp;
    exp = ref_prod(a, b, s);
    @(negedge clk);
    op_a = a; op_b = b; is_signed = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R5 busy after start", {63'd0, busy}, 64'd1);
    n = 0;
    while (!done && n <= W + 4) begin
      if (poke && n == 3) begin
        op_a = ~a; op_b = b ^ 32'h5a5a_0f0f; is_signed = ~s; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check("R5 latency", 64'(n), 64'(W));
    check(req, {hi, lo}, exp);
    @(negedge clk);
    check("R5 done one cycle", {62'd0, done, busy}, 64'd0);
    repeat (3) @(negedge clk);
    check("R7 hold", {hi, lo}, exp);
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    #3;
    check("R1 reset", {busy, done, hi, lo}, 66'd0);
    check("R1 reset w4", {56'd0, s4_busy, s4_done, s4_hi, s4_lo}, 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    @(negedge clk);
    s4_a = 4'b1101; s4_b = 4'b0101; s4_sgn = 1'b1; s4_start = 1'b1;
    @(negedge clk);
    s4_start = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 signed -3x5", {56'd0, s4_done, 7'd0, s4_hi, s4_lo}, {56'd0, 1'b1, 7'd0, 8'b11110001});

    run("R8 zero", 32'd0, 32'hffff_ffff, 1'b0, 1'b0);
    run("R8 all ones unsigned", 32'hffff_ffff, 32'hffff_ffff, 1'b0, 1'b0);
    run("R8 min squared", 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0);
    run("R8 min times -1", 32'h8000_0000, 32'hffff_ffff, 1'b1, 1'b0);
    run("R3 -3x5", 32'hffff_fffd, 32'd5, 1'b1, 1'b0);
    run("R2 -3x5 as unsigned", 32'hffff_fffd, 32'd5, 1'b0, 1'b0);
    run("R6 start ignored", 32'h1234_5678, 32'h9abc_def0, 1'b0, 1'b1);
    run("R6 start ignored signed", 32'hdead_beef, 32'h0000_7777, 1'b1, 1'b1);

    for (int i = 0; i < 30; i++) begin
      run("R2 unsigned random", $urandom, $urandom, 1'b0, 1'b0);
      run("R3 signed random", $urandom, $urandom, 1'b1, 1'b0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule